// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a host-side peripheral that runs one short transaction on a serial flash device each time software fills in its registers. It occupies a byte-wide window of eight registers. These hold an opcode, a mode/status byte, the low sixteen address bits and four data bytes. Software loads the opcode, the address and any write data first. It writes the mode byte last, and that write launches the frame on the SPI pins.

The upper nibble of the mode byte picks one of eleven fixed frame shapes. The shapes combine an opcode, a 3-byte address, write bytes, an engine-made dummy byte and read bytes. The lower nibble of the mode byte carries address bits 19:16, so the address on the wire is always three bytes with a zero top nibble. Bytes read from the device land in the data registers, and software collects them once the busy flag clears.

Top module: `spiCmdEngine`

## Requirements
- R1: Register window, selected by `regAddr`. Offset 0 is the opcode. Offset 2 is address bits 15:8 and offset 3 is address bits 7:0. Offsets 4 to 7 are data bytes 0 to 3. A write while idle to offsets 0 and 2 to 7 is read back unchanged. A read of offset 1 returns {busy, 3'b000, address bits 19:16}.
- R2: A write to offset 1 with a frame code from 1 to 11 in bits 7:4 starts a frame and stores bits 3:0 as address bits 19:16. Where a frame has an address, it is sent as bytes {4'h0, bits 19:16}, bits 15:8, bits 7:0.
- R3: Codes 1 to 6 send these bytes: 1 sends the opcode only. 2 sends the opcode and data byte 0. 3 sends the opcode and then clocks two read bytes. 4 sends the opcode and the address. 5 sends the opcode, the address and data byte 0. 6 sends the opcode, the address and data bytes 0 to 3.
- R4: Code 7 sends the opcode, the address and one dummy byte of 0x00, then clocks four read bytes.
- R5: Codes 8, 9, 10 and 11 send the opcode and the address, then clock 1, 2, 3 and 4 read bytes (code minus 7).
- R6: The n-th read byte of a frame is stored in data byte n (offset 4+n). Data bytes that the frame does not read keep their values.
- R7: A write to offset 1 with code 0 or 12 to 15 is ignored. Chip select stays high and no register changes.
- R8: Chip select is active low and drops in the cycle after the mode write. It stays low with SCK low for 2*SCK_HALF cycles before the first bit. Each bit is SCK_HALF cycles with SCK low, then SCK_HALF cycles with SCK high. Data goes out MSB first, and MOSI is 0 outside sent bits and during dummy and read bytes. MISO is sampled at the end of each high half. Chip select rises SCK_HALF cycles after the last falling SCK edge, and SCK rests low while chip select is high.
- R9: Busy is 1 from the cycle after the mode write until chip select rises. Every register write made while busy is discarded, including another mode write.
- R10: After reset all registers read 0, chip select is high, SCK and MOSI are low and busy is 0.
- R11: With the default divider, the longest frame (code 7) finishes within 2500 system cycles, which is 10 µs at 250 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational from regAddr) |
| busy | output | 1 | Frame in progress |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock, mode 0 |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
A mode write captured at clock edge E changes chip select and busy during the cycle right after E. The bench's reference model builds the whole expected waveform at E as a queue of per-cycle {busy, csN, SCK, MOSI} tuples: 2*SCK_HALF lead cycles, 2*SCK_HALF cycles per bit and SCK_HALF tail cycles. Each falling clock edge pops one tuple and compares it, so timing and data errors show up in the exact cycle they happen. Register contents, including the read bytes, are due once busy drops. The bench reads them only after the model reports idle, and reads the status byte one cycle after the mode write to see busy set.

// File: rtl/spiCmdPkg.sv
`timescale 1ns/1ps
package spiCmdPkg;

  typedef enum logic [2:0] {
    SRC_OPC, SRC_AHI, SRC_AMID, SRC_ALO, SRC_DATA, SRC_ZERO
  } srcSel_e;

  // Description of one byte slot inside a frame
  typedef struct packed {
    srcSel_e    src;
    logic       isRead;
    logic [1:0] idx;
  } slot_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       startCmd;
    logic       txEn;
    logic       loadTx;
    logic       shiftTx;
    srcSel_e    txSrc;
    logic [1:0] txIdx;
    logic       sampleRx;
    logic       storeRx;
    logic [1:0] rxIdx;
  } ctrlStrobe_t;

  function automatic logic codeValid(input logic [3:0] c);
    return (c >= 4'd1) && (c <= 4'd11);
  endfunction

  function automatic int addrBytes(input logic [3:0] c);
    return (c >= 4'd4) ? 3 : 0;
  endfunction

  function automatic int wrBytes(input logic [3:0] c);
    case (c)
      4'd2, 4'd5: return 1;
      4'd6:       return 4;
      default:    return 0;
    endcase
  endfunction

  function automatic int dummyBytes(input logic [3:0] c);
    return (c == 4'd7) ? 1 : 0;
  endfunction

  function automatic int rdBytes(input logic [3:0] c);
    if (c == 4'd3) return 2;
    if (c == 4'd7) return 4;
    if (c >= 4'd8 && c <= 4'd11) return int'(c) - 7;
    return 0;
  endfunction

  function automatic int frameLen(input logic [3:0] c);
    return 1 + addrBytes(c) + wrBytes(c) + dummyBytes(c) + rdBytes(c);
  endfunction

  function automatic slot_t frameSlot(input logic [3:0] c, input int b);
    slot_t s;
    int a;
    int w;
    int d;
    a = addrBytes(c);
    w = wrBytes(c);
    d = dummyBytes(c);
    s.src    = SRC_ZERO;
    s.isRead = 1'b0;
    s.idx    = 2'd0;
    if (b == 0) begin
      s.src = SRC_OPC;
    end else if (b <= a) begin
      s.src = (b == 1) ? SRC_AHI : (b == 2) ? SRC_AMID : SRC_ALO;
    end else if (b <= a + w) begin
      s.src = SRC_DATA;
      s.idx = 2'(b - 1 - a);
    end else if (b > a + w + d) begin
      s.isRead = 1'b1;
      s.idx    = 2'(b - 1 - a - w - d);
    end
    return s;
  endfunction

endpackage

// File: rtl/spiCmdCtrl.sv
`timescale 1ns/1ps
module spiCmdCtrl
  import spiCmdPkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic        busy,
  output logic        csN,
  output logic        sck,
  output ctrlStrobe_t strb
);

  localparam int BIT_CYC = 2 * SCK_HALF;
  localparam int CNT_W   = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(SCK_HALF);
  localparam logic [CNT_W-1:0] CNT_TAIL = CNT_W'(SCK_HALF - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TAIL} state_e;

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitIdx;
  logic [3:0]       byteIdx;
  logic [3:0]       codeQ;

  logic  modeWrite;
  logic  cntEnd;
  logic  byteEnd;
  logic  lastByte;
  slot_t curSlot;
  slot_t nxtSlot;

  always_comb begin
    modeWrite = regWe && (regAddr == 3'd1) && (state == ST_IDLE)
                && codeValid(regWrData[7:4]);
    cntEnd    = (cnt == CNT_LAST);
    byteEnd   = cntEnd && (bitIdx == 3'd7);
    lastByte  = (int'(byteIdx) == frameLen(codeQ) - 1);
    curSlot   = frameSlot(codeQ, int'(byteIdx));
    nxtSlot   = frameSlot(codeQ, int'(byteIdx) + 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
      codeQ   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (modeWrite) begin
            state <= ST_LEAD;
            cnt   <= '0;
            codeQ <= regWrData[7:4];
          end
        end
        ST_LEAD: begin
          if (cntEnd) begin
            state   <= ST_XFER;
            cnt     <= '0;
            bitIdx  <= '0;
            byteIdx <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (cntEnd) begin
            cnt    <= '0;
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == 3'd7) begin
              if (lastByte) state <= ST_TAIL;
              else          byteIdx <= byteIdx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CNT_TAIL) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    busy          = (state != ST_IDLE);
    csN           = (state == ST_IDLE);
    sck           = (state == ST_XFER) && (cnt >= CNT_HALF);
    strb.startCmd = modeWrite;
    strb.txEn     = (state == ST_XFER);
    strb.loadTx   = ((state == ST_LEAD) && cntEnd)
                    || ((state == ST_XFER) && byteEnd && !lastByte);
    strb.txSrc    = (state == ST_LEAD) ? SRC_OPC : nxtSlot.src;
    strb.txIdx    = nxtSlot.idx;
    strb.shiftTx  = (state == ST_XFER) && cntEnd && (bitIdx != 3'd7);
    strb.sampleRx = (state == ST_XFER) && cntEnd;
    strb.storeRx  = (state == ST_XFER) && byteEnd && curSlot.isRead;
    strb.rxIdx    = curSlot.idx;
  end

  AST_START_ON_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(regWe && regAddr == 3'd1)); // R2

  AST_IGNORE_BAD_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 3'd1 && !busy && !codeValid(regWrData[7:4])) |=> csN); // R7

  AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> $past(!sck)); // R8

endmodule

// File: rtl/spiCmdData.sv
`timescale 1ns/1ps
module spiCmdData
  import spiCmdPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        busy,
  input  logic        miso,
  input  ctrlStrobe_t strb,
  output logic        mosi
);

  logic [7:0]       opcodeR;
  logic [7:0]       addrMidR;
  logic [7:0]       addrLoR;
  logic [3:0]       addrNibR;
  logic [3:0][7:0]  dataR;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic [7:0]       txSrcByte;

  always_comb begin
    case (strb.txSrc)
      SRC_OPC:  txSrcByte = opcodeR;
      SRC_AHI:  txSrcByte = {4'h0, addrNibR};
      SRC_AMID: txSrcByte = addrMidR;
      SRC_ALO:  txSrcByte = addrLoR;
      SRC_DATA: txSrcByte = dataR[strb.txIdx];
      default:  txSrcByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeR  <= '0;
      addrMidR <= '0;
      addrLoR  <= '0;
      addrNibR <= '0;
      dataR    <= '0;
      txShift  <= '0;
      rxShift  <= '0;
    end else begin
      if (regWe && !busy) begin
        case (regAddr)
          3'd0:                      opcodeR  <= regWrData;
          3'd2:                      addrMidR <= regWrData;
          3'd3:                      addrLoR  <= regWrData;
          3'd4, 3'd5, 3'd6, 3'd7:    dataR[regAddr[1:0]] <= regWrData;
          default: ;
        endcase
      end
      if (strb.startCmd) addrNibR <= regWrData[3:0];
      if (strb.loadTx)        txShift <= txSrcByte;
      else if (strb.shiftTx)  txShift <= {txShift[6:0], 1'b0};
      if (strb.sampleRx) rxShift <= {rxShift[6:0], miso};
      if (strb.storeRx)  dataR[strb.rxIdx] <= {rxShift[6:0], miso};
    end
  end

  always_comb begin
    case (regAddr)
      3'd0:    regRdData = opcodeR;
      3'd1:    regRdData = {busy, 3'b000, addrNibR};
      3'd2:    regRdData = addrMidR;
      3'd3:    regRdData = addrLoR;
      default: regRdData = dataR[regAddr[1:0]];
    endcase
    mosi = strb.txEn & txShift[7];
  end

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && regAddr == 3'd0) |=> $stable(opcodeR)); // R9

  AST_STORE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeRx |-> busy); // R6

endmodule

// File: rtl/spiCmdEngine.sv
`timescale 1ns/1ps
module spiCmdEngine
  import spiCmdPkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       busy,
  output logic       spiCsN,
  output logic       spiSck,
  output logic       spiMosi,
  input  logic       spiMiso
);

  ctrlStrobe_t strb;

  spiCmdCtrl #(.SCK_HALF(SCK_HALF)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .busy      (busy),
    .csN       (spiCsN),
    .sck       (spiSck),
    .strb      (strb)
  );

  spiCmdData uData (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busy      (busy),
    .miso      (spiMiso),
    .strb      (strb),
    .mosi      (spiMosi)
  );

endmodule

// File: tb/spiCmdEngine_test.sv
`timescale 1ns/1ps
module spiCmdEngine_test;

  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       busy, spiCsN, spiSck, spiMosi;
  logic       spiMiso = 1'b0;

  always #2 clk = ~clk;

  spiCmdEngine #(.SCK_HALF(H)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string curReq = "R10";

  // expected {busy, csN, sck, mosi} per cycle
  logic [3:0] expQ[$];
  logic [3:0] expCur = 4'b0100;
  logic [7:0] mOpc = 0, mMid = 0, mLo = 0;
  logic [3:0] mNib = 0;
  logic [7:0] mData[4] = '{8'h0, 8'h0, 8'h0, 8'h0};
  logic [7:0] slaveBytes[9];

  function automatic void pushByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      for (int k = 0; k < H; k++) expQ.push_back({1'b1, 1'b0, 1'b0, v[i]});
      for (int k = 0; k < H; k++) expQ.push_back({1'b1, 1'b0, 1'b1, v[i]});
    end
  endfunction

  function automatic void buildFrame(input logic [3:0] code, input logic [3:0] nib);
    logic [7:0] fb[$];
    int nRd;
    int firstRd;
    fb.push_back(mOpc);
    if (code >= 4'd4) begin
      fb.push_back({4'h0, nib}); fb.push_back(mMid); fb.push_back(mLo);
    end
    if (code == 4'd2 || code == 4'd5) fb.push_back(mData[0]);
    if (code == 4'd6) for (int j = 0; j < 4; j++) fb.push_back(mData[j]);
    if (code == 4'd7) fb.push_back(8'h00);
    nRd = (code == 4'd3) ? 2 : (code == 4'd7) ? 4 : (code >= 4'd8) ? int'(code) - 7 : 0;
    firstRd = fb.size();
    for (int j = 0; j < nRd; j++) fb.push_back(8'h00);
    for (int k = 0; k < 2 * H; k++) expQ.push_back(4'b1000);
    foreach (fb[j]) pushByte(fb[j]);
    for (int k = 0; k < H; k++) expQ.push_back(4'b1000);
    for (int j = 0; j < nRd; j++) mData[j] = slaveBytes[firstRd + j];
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    logic wasBusy;
    cycles++;
    if (!rstN) begin
      expQ.delete();
      expCur = 4'b0100;
      mOpc = 0; mMid = 0; mLo = 0; mNib = 0;
      for (int j = 0; j < 4; j++) mData[j] = 0;
    end else begin
      wasBusy = expCur[3];
      if (regWe && !wasBusy) begin
        case (regAddr)
          3'd0: mOpc = regWrData;
          3'd1: if (regWrData[7:4] >= 4'd1 && regWrData[7:4] <= 4'd11) begin
                  mNib = regWrData[3:0];
                  buildFrame(regWrData[7:4], regWrData[3:0]);
                end
          3'd2: mMid = regWrData;
          3'd3: mLo = regWrData;
          default: mData[regAddr[1:0]] = regWrData;
        endcase
      end
      expCur = (expQ.size() > 0) ? expQ.pop_front() : 4'b0100;
    end
  end

  // cycle compare (R8 framing plus current frame requirement)
  always @(negedge clk) begin
    if (rstN) begin
      compared++;
      if ({busy, spiCsN, spiSck, spiMosi} !== expCur) begin
        mismatched++;
        $display("FAIL %s (R8 waveform) cycle %0d: {busy,csN,sck,mosi} got %b exp %b",
                 curReq, cycles, {busy, spiCsN, spiSck, spiMosi}, expCur);
      end
    end
  end

  // flash device model: MISO changes after each falling SCK
  int bitPos = 0;
  logic prevSck = 1'b0;
  always @(negedge clk) begin
    if (spiCsN) bitPos = 0;
    else if (prevSck && !spiSck) bitPos++;
    prevSck = spiSck;
    spiMiso = (bitPos < 72) ? slaveBytes[bitPos / 8][7 - (bitPos % 8)] : 1'b0;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles == 100000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, got %0d cycles exp fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regWe = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic readAll(input string req);
    logic [7:0] v;
    logic [7:0] e;
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), v);
      case (a)
        0: e = mOpc;
        1: e = {expCur[3], 3'b000, mNib};
        2: e = mMid;
        3: e = mLo;
        default: e = mData[a - 4];
      endcase
      chk(req, v, e);
    end
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (expCur[3]) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic runCase(input string req, input logic [3:0] code, input logic [3:0] nib,
                         input logic [7:0] seed, input logic probeBusy);
    logic [7:0] v;
    int busyCycles;
    curReq = req;
    for (int k = 0; k < 9; k++) slaveBytes[k] = seed + 8'(k * 29);
    writeReg(3'd0, seed ^ 8'h5A);
    writeReg(3'd2, seed + 8'd3);
    writeReg(3'd3, ~seed);
    for (int j = 0; j < 4; j++) writeReg(3'(4 + j), seed + 8'(j * 17 + 1));
    writeReg(3'd1, {code, nib});
    if (probeBusy) begin
      readReg(3'd1, v);
      chk("R9 status busy", v, {1'b1, 3'b000, nib});
      writeReg(3'd0, 8'hEE);      // dropped while busy
      writeReg(3'd1, 8'h1F);      // second start dropped
      writeReg(3'd5, 8'hEE);
    end
    busyCycles = 1;
    while (busy) begin
      @(negedge clk);
      busyCycles++;
    end
    if (code == 4'd7) begin
      compared++;
      if (busyCycles > 2500) begin
        mismatched++;
        $display("FAIL R11: got %0d busy cycles exp <= 2500", busyCycles);
      end
    end
    waitIdle();
    readAll(req);
  endtask

  initial begin
    logic [7:0] v;
    for (int k = 0; k < 9; k++) slaveBytes[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 csN", {7'b0, spiCsN}, 8'h01);
    chk("R10 sck", {7'b0, spiSck}, 8'h00);
    chk("R10 mosi/busy", {6'b0, spiMosi, busy}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), v);
      chk("R10 register", v, 8'h00);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1 register window
    curReq = "R1";
    writeReg(3'd0, 8'h9F); writeReg(3'd2, 8'h12); writeReg(3'd3, 8'h34);
    writeReg(3'd4, 8'h11); writeReg(3'd5, 8'h22); writeReg(3'd6, 8'h33); writeReg(3'd7, 8'h44);
    readAll("R1");

    // R3 short frames
    runCase("R3 code1", 4'd1, 4'h0, 8'h21, 1'b0);
    runCase("R3 code2", 4'd2, 4'h0, 8'hA5, 1'b0);
    runCase("R3 code3 R6", 4'd3, 4'h0, 8'h3C, 1'b0);
    runCase("R3 code4 R2", 4'd4, 4'hF, 8'h81, 1'b0);
    runCase("R3 code5", 4'd5, 4'h6, 8'h0F, 1'b0);
    runCase("R3 code6", 4'd6, 4'h9, 8'hC3, 1'b0);
    // R4 dummy + four reads, also R11 timing
    runCase("R4 code7 R11", 4'd7, 4'hA, 8'h77, 1'b0);
    // R5 address + n reads
    runCase("R5 code8", 4'd8, 4'h1, 8'h18, 1'b0);
    runCase("R5 code9", 4'd9, 4'h2, 8'hE4, 1'b0);
    runCase("R5 code10 R6", 4'd10, 4'h3, 8'h66, 1'b0);
    runCase("R5 code11", 4'd11, 4'h4, 8'h99, 1'b0);

    // R9 busy flag and dropped writes
    runCase("R9", 4'd11, 4'h5, 8'h2B, 1'b1);

    // R7 ignored codes
    curReq = "R7";
    writeReg(3'd1, 8'h0C); waitIdle(); readAll("R7 code0");
    writeReg(3'd1, 8'hC3); waitIdle(); readAll("R7 code12");
    writeReg(3'd1, 8'hF1); waitIdle(); readAll("R7 code15");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule